// File: doc/BRIEF.md
# DRAM Mode Register Load Sequencer

This block sits on the controller side of a DDR-style memory interface. It writes one value into either the base mode register or the extended mode register of the memory, using the required command sequence. A client raises a request with a register select and a 13-bit value. The sequencer takes the request only when it is ready and the bank-status input reports that every bank is idle.

After it takes a request, the sequencer issues a precharge-all command. It then waits out the row precharge time and issues the register load command. Next it waits the register load delay before it reports ready again. When the value goes to the base register with the DLL-reset bit set, a further lock interval is added to that last wait. The extended register never adds the lock interval. On every cycle that carries no required command, the command bus drives a no-operation.

Top module: `mrs_seq`

## Requirements
- R1: A request is acknowledged (`ack_o` high in the same cycle as `req_i`) only when `ready_o` is high and `banks_idle_i` is high. In any other case `ack_o` stays low.
- R2: The cycle after an acknowledge carries precharge-all. On `cmd_o` (ras_n, cas_n, we_n) this is 3'b010, with `addr_o` equal to 13'h0400 (only bit 10 set) and `ba_o` equal to 0.
- R3: The register load command (`cmd_o` = 3'b000) is issued exactly T_RP cycles after the precharge-all. `addr_o` carries the captured value, `ba_o[0]` carries the register select (0 = base, 1 = extended), and `ba_o[1]` is 0.
- R4: For a base-register load with value bit 8 clear, `ready_o` rises exactly T_MRD cycles after the load command.
- R5: For a base-register load with value bit 8 set (DLL reset), `ready_o` rises exactly T_MRD + T_DLL cycles after the load command.
- R6: For an extended-register load, `ready_o` rises T_MRD cycles after the load command, whatever the value of bit 8.
- R7: Every cycle that is not a precharge-all or a load command drives no-operation (`cmd_o` = 3'b111) with `addr_o` and `ba_o` equal to zero.
- R8: A request made while the sequencer is busy gets no acknowledge and does not change the sequence already in progress.
- R9: `ready_o` is high out of reset. It is low from the cycle after an acknowledge until the last wait ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request to load a mode register |
| req_ext_i | input | 1 | Register select: 0 = base, 1 = extended |
| req_val_i | input | 13 | Value to write |
| banks_idle_i | input | 1 | High when all banks are idle |
| ack_o | output | 1 | Request accepted this cycle |
| ready_o | output | 1 | Sequencer idle; normal commands may be issued |
| cmd_o | output | 3 | Command {ras_n, cas_n, we_n} |
| addr_o | output | 13 | Address bus |
| ba_o | output | 2 | Bank address |

## Verification
The case that is hardest to reach from the ports is a second request that arrives while a sequence is already running. Such a request must not restart the sequence or shorten any wait. To create it, the stimulus raises the request partway through the precharge wait of every transaction. It then checks that the acknowledge stays low and that the load command and the rise of ready still fall on their computed cycles. The sweep covers both register selects and walks a single set bit across all 13 value positions. This way, only bit 8 written to the base register produces the long lock wait.

// File: rtl/mrs_seq_pkg.sv
package mrs_seq_pkg;
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_WRP,
    ST_MRS,
    ST_WMRD
  } state_e;

  localparam int unsigned DLL_BIT = 8;
  localparam int unsigned AP_BIT  = 10;
endpackage

// File: rtl/mrs_seq_timer.sv
module mrs_seq_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mrs_seq_drv.sv
module mrs_seq_drv
  import mrs_seq_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  state_e        state_i,
  input  logic          ext_i,
  input  logic [AW-1:0] val_i,
  output logic [2:0]    cmd_o,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    ba_o
);
  always_comb begin
    cmd_o  = CMD_NOP;
    addr_o = '0;
    ba_o   = '0;
    unique case (state_i)
      ST_PRE: begin
        cmd_o          = CMD_PRE;
        addr_o[AP_BIT] = 1'b1;
      end
      ST_MRS: begin
        cmd_o  = CMD_MRS;
        addr_o = val_i;
        ba_o   = {1'b0, ext_i};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mrs_seq.sv
module mrs_seq
  import mrs_seq_pkg::*;
#(
  parameter int unsigned AW    = 13,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_MRD = 2,
  parameter int unsigned T_DLL = 200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_ext_i,
  input  logic [AW-1:0] req_val_i,
  input  logic          banks_idle_i,
  output logic          ack_o,
  output logic          ready_o,
  output logic [2:0]    cmd_o,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    ba_o
);
  localparam int unsigned MAXW = T_MRD + T_DLL + T_RP;
  localparam int unsigned CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] LD_RP   = CW'(T_RP - 2);
  localparam logic [CW-1:0] LD_MRD  = CW'(T_MRD - 2);
  localparam logic [CW-1:0] LD_LOCK = CW'(T_MRD + T_DLL - 2);

  state_e        state_q, state_d;
  logic          ext_q, dll_q;
  logic [AW-1:0] val_q;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  assign ready_o = (state_q == ST_IDLE);
  assign ack_o   = ready_o && req_i && banks_idle_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (ack_o)    state_d = ST_PRE;
      ST_PRE:                state_d = ST_WRP;
      ST_WRP:  if (tmr_zero) state_d = ST_MRS;
      ST_MRS:                state_d = ST_WMRD;
      ST_WMRD: if (tmr_zero) state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ext_q   <= 1'b0;
      dll_q   <= 1'b0;
      val_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ack_o) begin
        ext_q <= req_ext_i;
        val_q <= req_val_i;
        // only the base register carries the DLL reset control
        dll_q <= !req_ext_i && req_val_i[DLL_BIT];
      end
    end
  end

  assign tmr_load = (state_q == ST_PRE) || (state_q == ST_MRS);
  assign tmr_val  = (state_q == ST_PRE) ? LD_RP : (dll_q ? LD_LOCK : LD_MRD);

  mrs_seq_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  mrs_seq_drv #(.AW(AW)) u_drv (
    .state_i (state_q),
    .ext_i   (ext_q),
    .val_i   (val_q),
    .cmd_o   (cmd_o),
    .addr_o  (addr_o),
    .ba_o    (ba_o)
  );

  // elapsed-cycle counters for timing checks
  logic [CW-1:0] since_pre_q, since_mrs_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_pre_q <= '0;
      since_mrs_q <= '0;
    end else begin
      if (cmd_o == CMD_PRE)        since_pre_q <= CW'(1);
      else if (since_pre_q != '1)  since_pre_q <= since_pre_q + 1'b1;
      if (cmd_o == CMD_MRS)        since_mrs_q <= CW'(1);
      else if (since_mrs_q != '1)  since_mrs_q <= since_mrs_q + 1'b1;
    end
  end

  p_ack_gated_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (banks_idle_i && ready_o));

  p_pre_after_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> (cmd_o == CMD_PRE && addr_o[AP_BIT]));

  p_rp_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_MRS) |-> (since_pre_q >= CW'(T_RP)));

  p_mrd_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (since_mrs_q >= CW'(T_MRD)));

  p_busy_after_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ready_o);
endmodule

// File: tb/mrs_seq_tb.sv
module mrs_seq_tb;
  localparam int unsigned AW    = 13;
  localparam int unsigned T_RP  = 3;
  localparam int unsigned T_MRD = 2;
  localparam int unsigned T_DLL = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          req_ext_i = 1'b0;
  logic [AW-1:0] req_val_i = '0;
  logic          banks_idle_i = 1'b1;
  logic          ack_o, ready_o;
  logic [2:0]    cmd_o;
  logic [AW-1:0] addr_o;
  logic [1:0]    ba_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  mrs_seq #(.AW(AW), .T_RP(T_RP), .T_MRD(T_MRD), .T_DLL(T_DLL)) u_dut (
    .clk_i, .rst_ni, .req_i, .req_ext_i, .req_val_i, .banks_idle_i,
    .ack_o, .ready_o, .cmd_o, .addr_o, .ba_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic nop_chk(input string tag);
    chk(tag, {29'd0, cmd_o}, 32'h7);
    chk(tag, {19'd0, addr_o}, 32'h0);
    chk(tag, {30'd0, ba_o}, 32'h0);
  endtask

  task automatic txn(input logic ext, input logic [AW-1:0] val);
    int w;
    string rtag;
    step(); req_i = 1'b1; req_ext_i = ext; req_val_i = val; #1;
    chk("R1 ack", {31'd0, ack_o}, 32'd1);
    step(); req_i = 1'b0; req_val_i = ~val; #1;
    chk("R2 cmd", {29'd0, cmd_o}, 32'h2);
    chk("R2 addr", {19'd0, addr_o}, 32'h400);
    chk("R2 ba", {30'd0, ba_o}, 32'h0);
    chk("R9 busy", {31'd0, ready_o}, 32'd0);
    for (int i = 1; i < T_RP; i++) begin
      step(); req_i = (i == 1); #1;
      chk("R8 no ack", {31'd0, ack_o}, 32'd0);
      nop_chk("R7 rp gap");
    end
    step(); req_i = 1'b0; #1;
    chk("R3 cmd", {29'd0, cmd_o}, 32'h0);
    chk("R3 addr", {19'd0, addr_o}, {19'd0, val});
    chk("R3 ba", {30'd0, ba_o}, {31'd0, ext});
    w = T_MRD + ((!ext && val[8]) ? T_DLL : 0);
    rtag = ext ? "R6" : (val[8] ? "R5" : "R4");
    for (int i = 1; i < w; i++) begin
      step(); #1;
      chk({rtag, " busy"}, {31'd0, ready_o}, 32'd0);
      nop_chk("R7 mrd gap");
    end
    step(); #1;
    chk({rtag, " ready"}, {31'd0, ready_o}, 32'd1);
    nop_chk("R7 idle");
  endtask

  initial begin
    #25; #1;
    chk("R9 reset ready", {31'd0, ready_o}, 32'd1);
    nop_chk("R7 reset");
    rst_ni = 1'b1;
    // banks not idle: request must be held off
    step(); banks_idle_i = 1'b0; req_i = 1'b1; req_val_i = 13'h155;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R1 not idle", {31'd0, ack_o}, 32'd0);
      chk("R1 ready kept", {31'd0, ready_o}, 32'd1);
      nop_chk("R7 held");
      step();
    end
    req_i = 1'b0; banks_idle_i = 1'b1;
    for (int e = 0; e < 2; e++) begin
      for (int k = 0; k < AW; k++) txn(e[0], AW'(1) << k);
      txn(e[0], 13'h1FFF);
      txn(e[0], 13'h0000);
      txn(e[0], 13'h0123);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule